// File: doc/BRIEF.md
# Power Management Control Register Unit

This unit holds the control settings for a few platform power-management signals and runs a periodic system-management interrupt (SMI) timer. Software writes the settings through a small address/data port: a CPU-sleep enable, a clock-run enable and a two-bit rate select share one control register. The global SMI enable sits in a second register, and a write-once lock bit can freeze it until the next platform reset.

The periodic timer counts one-second ticks from an external time base. When the selected interval runs out it emits a single-clock SMI pulse and starts the next interval. It pulses only while the global SMI enable is set. The power-state inputs and the enable bits together drive three outputs. The CPU sleep output follows S1 when its enable is set, and deep C-states force it active. The clock-run drive is forced low unless clock-run control is enabled, and it is always forced low during sleep entry. The PCI clock-stop request passes through only while clock-run control is active.

Top module: `pm_ctrl_unit`

## Requirements
- R1: After platform reset every register reads 0, the rate select is 00, perSmi is 0, cpuSlp is 0, pciClkStop is 0 and clkRunLow is 1.
- R2: Address 0 is the control register: bit 0 is the CPU-sleep enable, bit 1 the clock-run enable, bits 3:2 the rate select and bit 7 the lock. Address 1 bit 0 is the global SMI enable. Reserved bits and unused addresses read 0 and ignore writes.
- R3: Writing 1 to the lock bit sets it. Writing 0 to it has no effect, and only platform reset clears it.
- R4: While the lock is set, writes to the global SMI enable are ignored.
- R5: With the SMI enable set, perSmi gives a one-clock pulse on the clock after the tick that completes the interval. The interval is 64, 32, 16 or 8 ticks for rate 00, 01, 10 or 11, and the timer then starts the next interval at once.
- R6: While the global SMI enable is 0, no perSmi pulse occurs and the interval count is held at zero.
- R7: A control write that changes the rate select restarts the count, so the next pulse comes one full new interval after the write.
- R8: With clock-run enable 0, clkRunLow is 1 and pciClkStop is 0. With it 1 and no sleep entry, clkRunLow is 0 and pciClkStop follows clkStopReq.
- R9: While sleepEn is 1, clkRunLow is 1 and pciClkStop is 0 whatever the clock-run enable says.
- R10: In S1 (no C3/C4), cpuSlp equals the CPU-sleep enable bit. Outside S1, C3 and C4 it is 0.
- R11: cpuSlp is 1 whenever inC3 or inC4 is 1, regardless of the CPU-sleep enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstPlatN | input | 1 | Platform reset, active low |
| regAddr | input | 2 | Register address |
| regWrData | input | 8 | Write data |
| regWrEn | input | 1 | Write strobe |
| regRdData | output | 8 | Read data for regAddr (combinational) |
| secTick | input | 1 | One-clock pulse per second of the time base |
| inS1 | input | 1 | Platform in S1 |
| inC3 | input | 1 | Processor in C3 |
| inC4 | input | 1 | Processor in C4 |
| sleepEn | input | 1 | Sleep entry in progress |
| clkStopReq | input | 1 | Request from clock-run logic to stop the PCI clock |
| cpuSlp | output | 1 | CPU sleep, active high |
| clkRunLow | output | 1 | 1 forces the clock-run line low |
| pciClkStop | output | 1 | PCI clock stop, active high |
| perSmi | output | 1 | Periodic SMI pulse |

## Verification
The timer is run at each of the four rates from a cleared count. The bench counts the ticks to the first pulse and then to the second, which separates a wrong interval decode from a faulty reload. A rate change part-way through an interval shows whether the count restarts or keeps going. A long run of ticks with SMI disabled exposes any pulse that leaks out. Random combinations of power states, sleep entry, stop request and enable bits are compared with the combining rules, and the lock sequence covers writes of both values before and after the lock is set, then a reset.

// File: rtl/pm_ctrl_pkg.sv
package pm_ctrl_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;
  localparam int RATE_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_SMI  = 2'd1;

  localparam int BIT_CPUSLP = 0;
  localparam int BIT_CLKRUN = 1;
  localparam int BIT_RATE   = 2;
  localparam int BIT_LOCK   = 7;
  localparam int BIT_SMIEN  = 0;

  typedef struct packed {
    logic              cpuSlpEn;
    logic              clkRunEn;
    logic [RATE_W-1:0] rate;
    logic              lock;
    logic              smiEn;
  } ctrlState_t;

  typedef struct packed {
    logic restart;
  } ctrlStrobes_t;
endpackage

// File: rtl/pm_ctrl_regs.sv
module pm_ctrl_regs
  import pm_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrEn,
  output logic [DATA_W-1:0] rdData,
  output ctrlState_t        state,
  output ctrlStrobes_t      strobes
);
  logic              ctrlHit;
  logic              smiHit;
  logic [RATE_W-1:0] newRate;

  assign ctrlHit = wrEn && (addr == ADDR_CTRL);
  assign smiHit  = wrEn && (addr == ADDR_SMI);
  assign newRate = wrData[BIT_RATE +: RATE_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= '0;
    end else begin
      if (ctrlHit) begin
        state.cpuSlpEn <= wrData[BIT_CPUSLP];
        state.clkRunEn <= wrData[BIT_CLKRUN];
        state.rate     <= newRate;
        if (wrData[BIT_LOCK]) state.lock <= 1'b1;
      end
      if (smiHit && !state.lock) state.smiEn <= wrData[BIT_SMIEN];
    end
  end

  always_comb begin
    strobes = '0;
    strobes.restart = ctrlHit && (newRate != state.rate);
  end

  always_comb begin
    rdData = '0;
    unique case (addr)
      ADDR_CTRL: begin
        rdData[BIT_CPUSLP]            = state.cpuSlpEn;
        rdData[BIT_CLKRUN]            = state.clkRunEn;
        rdData[BIT_RATE +: RATE_W]    = state.rate;
        rdData[BIT_LOCK]              = state.lock;
      end
      ADDR_SMI: rdData[BIT_SMIEN] = state.smiEn;
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/pm_ctrl_datapath.sv
module pm_ctrl_datapath
  import pm_ctrl_pkg::*;
#(
  parameter int BASE_INTERVAL = 64
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlState_t   state,
  input  ctrlStrobes_t strobes,
  input  logic         secTick,
  input  logic         inS1,
  input  logic         inC3,
  input  logic         inC4,
  input  logic         sleepEn,
  input  logic         clkStopReq,
  output logic         cpuSlp,
  output logic         clkRunLow,
  output logic         pciClkStop,
  output logic         perSmi
);
  localparam int CNT_W = $clog2(BASE_INTERVAL) + 1;
  localparam logic [CNT_W-1:0] BASE_V = CNT_W'(BASE_INTERVAL);

  logic [CNT_W-1:0] tickCnt;
  logic [CNT_W-1:0] intervalSel;
  logic [CNT_W-1:0] lastCount;
  logic             clkRunActive;

  assign intervalSel = BASE_V >> state.rate;
  assign lastCount   = intervalSel - 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
      perSmi  <= 1'b0;
    end else begin
      perSmi <= 1'b0;
      if (strobes.restart || !state.smiEn) begin
        tickCnt <= '0;
      end else if (secTick) begin
        if (tickCnt == lastCount) begin
          tickCnt <= '0;
          perSmi  <= 1'b1;
        end else begin
          tickCnt <= tickCnt + 1'b1;
        end
      end
    end
  end

  assign clkRunActive = state.clkRunEn && !sleepEn;
  assign clkRunLow    = !clkRunActive;
  assign pciClkStop   = clkRunActive && clkStopReq;
  assign cpuSlp       = (inS1 && state.cpuSlpEn) || inC3 || inC4;
endmodule

// File: rtl/pm_ctrl_unit.sv
module pm_ctrl_unit
  import pm_ctrl_pkg::*;
#(
  parameter int BASE_INTERVAL = 64
) (
  input  logic              clk,
  input  logic              rstPlatN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              regWrEn,
  output logic [DATA_W-1:0] regRdData,
  input  logic              secTick,
  input  logic              inS1,
  input  logic              inC3,
  input  logic              inC4,
  input  logic              sleepEn,
  input  logic              clkStopReq,
  output logic              cpuSlp,
  output logic              clkRunLow,
  output logic              pciClkStop,
  output logic              perSmi
);
  ctrlState_t   ctrlState;
  ctrlStrobes_t ctrlStrobes;
  logic         lockBit;
  logic         smiEn;

  assign lockBit = ctrlState.lock;
  assign smiEn   = ctrlState.smiEn;

  pm_ctrl_regs u_regs (
    .clk     (clk),
    .rstN    (rstPlatN),
    .addr    (regAddr),
    .wrData  (regWrData),
    .wrEn    (regWrEn),
    .rdData  (regRdData),
    .state   (ctrlState),
    .strobes (ctrlStrobes)
  );

  pm_ctrl_datapath #(.BASE_INTERVAL(BASE_INTERVAL)) u_dp (
    .clk        (clk),
    .rstN       (rstPlatN),
    .state      (ctrlState),
    .strobes    (ctrlStrobes),
    .secTick    (secTick),
    .inS1       (inS1),
    .inC3       (inC3),
    .inC4       (inC4),
    .sleepEn    (sleepEn),
    .clkStopReq (clkStopReq),
    .cpuSlp     (cpuSlp),
    .clkRunLow  (clkRunLow),
    .pciClkStop (pciClkStop),
    .perSmi     (perSmi)
  );
endmodule

// File: rtl/pm_ctrl_unit_chk.sv
module pm_ctrl_unit_chk (
  input logic clk,
  input logic rstPlatN,
  input logic lockBit,
  input logic smiEn,
  input logic perSmi,
  input logic secTick,
  input logic sleepEn,
  input logic clkRunLow,
  input logic inC3,
  input logic inC4,
  input logic cpuSlp
);
  // R3
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rstPlatN)
    lockBit |=> lockBit);

  // R4
  smi_frozen_chk: assert property (@(posedge clk) disable iff (!rstPlatN)
    lockBit |=> $stable(smiEn));

  // R5
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rstPlatN)
    perSmi |=> !perSmi);

  // R6
  pulse_enabled_chk: assert property (@(posedge clk) disable iff (!rstPlatN)
    perSmi |-> ($past(smiEn) && $past(secTick)));

  // R9
  sleep_clkrun_chk: assert property (@(posedge clk) disable iff (!rstPlatN)
    sleepEn |-> clkRunLow);

  // R11
  deep_cstate_chk: assert property (@(posedge clk) disable iff (!rstPlatN)
    (inC3 || inC4) |-> cpuSlp);
endmodule

bind pm_ctrl_unit pm_ctrl_unit_chk u_chk (
  .clk       (clk),
  .rstPlatN  (rstPlatN),
  .lockBit   (lockBit),
  .smiEn     (smiEn),
  .perSmi    (perSmi),
  .secTick   (secTick),
  .sleepEn   (sleepEn),
  .clkRunLow (clkRunLow),
  .inC3      (inC3),
  .inC4      (inC4),
  .cpuSlp    (cpuSlp)
);

// File: tb/pm_ctrl_unit_bench.sv
module pm_ctrl_unit_bench;
  logic       clk = 1'b0;
  logic       rstPlatN = 1'b0;
  logic [1:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regRdData;
  logic       secTick = 1'b0;
  logic       inS1 = 1'b0, inC3 = 1'b0, inC4 = 1'b0;
  logic       sleepEn = 1'b0, clkStopReq = 1'b0;
  logic       cpuSlp, clkRunLow, pciClkStop, perSmi;

  int checks = 0;
  int errors = 0;
  int pulseCount = 0;
  int wideCount = 0;
  logic prevPulse = 1'b0;

  always #4 clk = ~clk;

  pm_ctrl_unit u_pm_ctrl_unit (
    .clk(clk), .rstPlatN(rstPlatN), .regAddr(regAddr), .regWrData(regWrData),
    .regWrEn(regWrEn), .regRdData(regRdData), .secTick(secTick), .inS1(inS1),
    .inC3(inC3), .inC4(inC4), .sleepEn(sleepEn), .clkStopReq(clkStopReq),
    .cpuSlp(cpuSlp), .clkRunLow(clkRunLow), .pciClkStop(pciClkStop), .perSmi(perSmi)
  );

  always @(posedge clk) begin
    if (perSmi) pulseCount <= pulseCount + 1;
    if (perSmi && prevPulse) wideCount <= wideCount + 1;
    prevPulse <= perSmi;
  end

  function automatic int expInterval(input logic [1:0] r);
    return 64 >> r;
  endfunction
  function automatic logic expCpuSlp(input logic en, input logic s1, input logic c3, input logic c4);
    return (s1 && en) || c3 || c4;
  endfunction
  function automatic logic expClkRunLow(input logic en, input logic slp);
    return !en || slp;
  endfunction
  function automatic logic expPciStop(input logic en, input logic slp, input logic req);
    return en && !slp && req;
  endfunction

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic oneTick();
    @(negedge clk); secTick = 1'b1;
    @(negedge clk); secTick = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic ticksToPulse(output int n);
    int start;
    start = pulseCount;
    n = 0;
    for (int i = 1; i <= 200; i++) begin
      oneTick();
      if (pulseCount != start) begin n = i; break; end
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstPlatN = 1'b0;
    @(negedge clk); @(negedge clk); rstPlatN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int n;
    void'($urandom(32'd1234));
    doReset();

    // R1: reset state
    regRead(2'd0, rd); check("R1 ctrl", rd, 0);
    regRead(2'd1, rd); check("R1 smi", rd, 0);
    check("R1 perSmi", perSmi, 0);
    check("R1 cpuSlp", cpuSlp, 0);
    check("R1 clkRunLow", clkRunLow, 1);
    check("R1 pciClkStop", pciClkStop, 0);

    // R2: layout and reserved bits (lock bit left 0)
    regWrite(2'd0, 8'h7F); regRead(2'd0, rd); check("R2 ctrl readback", rd, 8'h0F);
    regWrite(2'd0, 8'h06); regRead(2'd0, rd); check("R2 ctrl fields", rd, 8'h06);
    regWrite(2'd1, 8'hFF); regRead(2'd1, rd); check("R2 smi readback", rd, 8'h01);
    regWrite(2'd2, 8'hFF); regRead(2'd2, rd); check("R2 unused addr2", rd, 0);
    regRead(2'd0, rd); check("R2 ctrl untouched", rd, 8'h06);
    regWrite(2'd1, 8'h00);

    // R8 R9 R10 R11: random combinations of enables and power states
    for (int i = 0; i < 40; i++) begin
      logic eSlp, eRun;
      eSlp = 1'($urandom); eRun = 1'($urandom);
      regWrite(2'd0, {6'b0, eRun, eSlp});
      @(negedge clk);
      inS1 = 1'($urandom); inC3 = ($urandom % 4) == 0; inC4 = ($urandom % 4) == 0;
      sleepEn = 1'($urandom); clkStopReq = 1'($urandom);
      #1;
      check("R10 R11 cpuSlp", cpuSlp, expCpuSlp(eSlp, inS1, inC3, inC4));
      check("R8 R9 clkRunLow", clkRunLow, expClkRunLow(eRun, sleepEn));
      check("R8 R9 pciClkStop", pciClkStop, expPciStop(eRun, sleepEn, clkStopReq));
    end
    // directed corners
    regWrite(2'd0, 8'h00);
    @(negedge clk); inS1 = 1; inC3 = 0; inC4 = 0; sleepEn = 0; clkStopReq = 1; #1;
    check("R10 S1 enable clear", cpuSlp, 0);
    check("R8 run disabled", clkRunLow, 1);
    @(negedge clk); inS1 = 0; inC4 = 1; #1; check("R11 C4 forced", cpuSlp, 1);
    regWrite(2'd0, 8'h03);
    @(negedge clk); inC4 = 0; inS1 = 1; sleepEn = 1; #1;
    check("R10 S1 enable set", cpuSlp, 1);
    check("R9 sleep override", clkRunLow, 1);
    check("R9 sleep stop blocked", pciClkStop, 0);
    @(negedge clk); sleepEn = 0; #1;
    check("R8 run active", clkRunLow, 0);
    check("R8 stop follows", pciClkStop, 1);
    @(negedge clk); inS1 = 0; clkStopReq = 0;

    // R5: each rate, first and second interval
    for (int r = 3; r >= 0; r--) begin
      regWrite(2'd1, 8'h00);
      regWrite(2'd0, {4'b0, 2'(r), 2'b00});
      regWrite(2'd1, 8'h01);
      ticksToPulse(n); check("R5 first interval", n, expInterval(2'(r)));
      ticksToPulse(n); check("R5 reload interval", n, expInterval(2'(r)));
    end
    check("R5 single cycle pulse", wideCount, 0);

    // R6: disabled, no pulses
    regWrite(2'd1, 8'h00);
    n = pulseCount;
    for (int i = 0; i < 70; i++) oneTick();
    check("R6 no pulse disabled", pulseCount - n, 0);

    // R7: rate change restarts count
    regWrite(2'd0, 8'h00);
    regWrite(2'd1, 8'h01);
    for (int i = 0; i < 10; i++) oneTick();
    regWrite(2'd0, 8'h0C);
    ticksToPulse(n); check("R7 restart after rate change", n, 8);

    // R3 R4: lock behaviour
    regWrite(2'd0, 8'h8C);
    regRead(2'd0, rd); check("R3 lock set", rd, 8'h8C);
    regWrite(2'd1, 8'h00);
    regRead(2'd1, rd); check("R4 smi write ignored", rd, 1);
    ticksToPulse(n); check("R4 pulses continue locked", n, 8);
    regWrite(2'd0, 8'h0C);
    regRead(2'd0, rd); check("R3 lock write 0 ignored", rd, 8'h8C);
    doReset();
    regRead(2'd0, rd); check("R3 lock cleared by reset", rd, 0);
    regRead(2'd1, rd); check("R1 smi after reset", rd, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule